// File: doc/BRIEF.md
# Time-of-Day Alarm and Aligned Pulse Generator

This block sits beside a free-running 64-bit nanosecond time counter. On every tick of that counter it receives the current time and the number of nanoseconds the tick added. It compares the time against two programmable alarm values. When an alarm matches, the block raises a one-cycle event strobe and a one-cycle pulse on that alarm's pin.

It also produces three fixed-period pulse trains. These trains do not run from reset. They are armed by a run enable and start with their phase at zero when alarm 1 fires. Software therefore programs alarm 1 to one clock period before a whole-second boundary, and the trains come out aligned to the second. A later alarm 1 match brings the trains back to phase zero, unless realignment is turned off. The pulses of trains 1 and 2 can also be copied onto loopback outputs.

Top module: `tod_alarm_pulse`

## Requirements
- R1: While reset is held and in the first cycle after it, `evt`, `pulse_pin` and `loop_out` are zero and each `alarm_pin` bit sits at its idle level. The idle level is the inverse of the matching `alarm_pol` bit. No alarm is armed after reset.
- R2: Writes go through `wr_addr` as follows:
  - 0 is the alarm 1 upper word; 1 is the alarm 1 lower word.
  - 2 is the alarm 2 upper word; 3 is the alarm 2 lower word.
  - 4, 5 and 6 are the periods of trains 1, 2 and 3.

  An armed alarm fires on the first tick where `now_ns` is greater than or equal to its 64-bit value, compared unsigned. On the clock edge of that tick it sets `evt` bit 16 (alarm 1) or bit 17 (alarm 2) for one cycle.
- R3: An alarm that has fired stays quiet on later ticks. Writing its lower word does not arm it. Writing its upper word arms it again.
- R4: `alarm_pol` bit 0 sets the polarity of alarm 1 and bit 1 sets the polarity of alarm 2. A value of 1 makes the pin pulse high for one cycle when the alarm fires. A value of 0 makes the pin idle high and pulse low.
- R5: No alarm fires in a cycle without `tick`, even when the time is past the compare value.
- R6: A train stays idle until `run_en` is 1 and alarm 1 fires. Pulling `run_en` low stops all trains at once and clears their phase.
- R7: Once started, a train adds `tick_inc` to its phase on every tick, beginning from 0. When the sum reaches or exceeds the train's period, it subtracts the period and keeps the remainder. On that edge it drives its pin and its event bit high for one cycle. The event bits are 7, 6 and 5 for trains 1, 2 and 3.
- R8: A train whose period is 0 never pulses.
- R9: If alarm 1 fires while the trains are running and `no_realign` is 0, every train's phase returns to 0 and no train pulses on that tick. If `no_realign` is 1, the match does not affect the trains.
- R10: `loop_out[0]` copies train 1's pulse when `loop_en[0]` is 1. `loop_out[1]` copies train 2's pulse when `loop_en[1]` is 1. Both copies appear in the same cycle as the pin. `loop_out[2]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time counter advanced this cycle |
| tick_inc | input | 8 | Nanoseconds added by this tick |
| now_ns | input | 64 | Current time in nanoseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R2) |
| wr_data | input | 32 | Register write data |
| alarm_pol | input | 2 | Per-alarm pin polarity, 1 = active high |
| run_en | input | 1 | Allow the pulse trains to run |
| no_realign | input | 1 | Ignore alarm 1 matches once trains run |
| loop_en | input | 2 | Loopback enable for trains 1 and 2 |
| evt | output | 32 | Event strobes: bits 17,16 alarms; 7,6,5 trains |
| alarm_pin | output | 2 | Alarm pins, polarity per `alarm_pol` |
| pulse_pin | output | 3 | Train pulse pins |
| loop_out | output | 3 | Loopback copies of train pulses |

## Verification
Two events can land on the same tick. The first case is an alarm 1 match on the very tick at which train 1's phase would reach its period. The bench sets this up by advancing the phase to one increment short of the period and then placing the alarm value on the next tick. It expects event bit 16 with no train pulse, followed by a fresh count that starts from zero. The same tick is then repeated with realignment disabled, where the pulse must appear on schedule. The second case arms both alarms with one value. On a single tick the bench expects bits 16 and 17 together, with each pin moving in its own direction.

// File: rtl/tod_ap_pkg.sv
package tod_ap_pkg;

    localparam int TIME_W  = 64;
    localparam int REG_W   = 32;
    localparam int INC_W   = 8;
    localparam int N_ALARM = 2;
    localparam int N_TRAIN = 3;
    localparam int N_LOOP  = 2;

    typedef enum logic [2:0] {
        A_AL1_HI = 3'd0,
        A_AL1_LO = 3'd1,
        A_AL2_HI = 3'd2,
        A_AL2_LO = 3'd3,
        A_PER1   = 3'd4,
        A_PER2   = 3'd5,
        A_PER3   = 3'd6
    } reg_addr_e;

    localparam int EVT_W      = 32;
    localparam int E_ALARM1   = 16;
    localparam int E_TRAIN1   = 7;

    typedef struct packed {
        logic [TIME_W-1:0] cmp;
        logic              armed;
    } alarm_st_t;

    function automatic int alarm_evt_bit(input int k);
        return E_ALARM1 + k;
    endfunction

    function automatic int train_evt_bit(input int i);
        return E_TRAIN1 - i;
    endfunction

endpackage

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
    import tod_ap_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [TW-1:0] now_ns,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [RW-1:0] wr_data,
    input  logic          active_high,
    output logic          hit,
    output logic          fire,
    output logic          pin
);
    localparam int HI_W = TW - RW;

    alarm_st_t st;

    assign hit = tick && st.armed && (now_ns >= st.cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            fire <= 1'b0;
        end else begin
            fire <= hit;
            if (hit)
                st.armed <= 1'b0;
            if (wr_lo)
                st.cmp[RW-1:0] <= wr_data;
            if (wr_hi) begin
                st.cmp[TW-1:RW] <= wr_data[HI_W-1:0];
                st.armed        <= 1'b1;
            end
        end
    end

    assign pin = active_high ? fire : ~fire;

endmodule

// File: rtl/tod_pulse_train.sv
module tod_pulse_train
    import tod_ap_pkg::*;
#(
    parameter int RW   = REG_W,
    parameter int INCW = INC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [INCW-1:0] inc,
    input  logic [RW-1:0]   period,
    input  logic            run,
    input  logic            align,
    input  logic            hold_phase,
    input  logic            loop_en,
    output logic            pulse,
    output logic            loop_q
);
    logic [RW-1:0] phase;
    logic          active;
    logic [RW:0]   sum;
    logic [RW:0]   per_ext;

    assign sum     = {1'b0, phase} + (RW+1)'(inc);
    assign per_ext = {1'b0, period};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            active <= 1'b0;
            pulse  <= 1'b0;
            loop_q <= 1'b0;
        end else begin
            pulse  <= 1'b0;
            loop_q <= 1'b0;
            if (!run) begin
                active <= 1'b0;
                phase  <= '0;
            end else if (align && (!active || !hold_phase)) begin
                active <= 1'b1;
                phase  <= '0;
            end else if (active && tick && (period != '0)) begin
                if (sum >= per_ext) begin
                    pulse  <= 1'b1;
                    loop_q <= loop_en;
                    phase  <= RW'(sum - per_ext);
                end else begin
                    phase  <= sum[RW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/tod_alarm_pulse.sv
module tod_alarm_pulse
    import tod_ap_pkg::*;
#(
    parameter int TW   = TIME_W,
    parameter int RW   = REG_W,
    parameter int INCW = INC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [INCW-1:0]    tick_inc,
    input  logic [TW-1:0]      now_ns,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [RW-1:0]      wr_data,
    input  logic [N_ALARM-1:0] alarm_pol,
    input  logic               run_en,
    input  logic               no_realign,
    input  logic [N_LOOP-1:0]  loop_en,
    output logic [EVT_W-1:0]   evt,
    output logic [N_ALARM-1:0] alarm_pin,
    output logic [N_TRAIN-1:0] pulse_pin,
    output logic [N_TRAIN-1:0] loop_out
);
    logic [N_ALARM-1:0] hit;
    logic [N_ALARM-1:0] fire;
    logic [RW-1:0]      period [N_TRAIN];

    for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
        logic wr_hi, wr_lo;
        assign wr_hi = wr_en && (wr_addr == 3'(int'(A_AL1_HI) + 2*k));
        assign wr_lo = wr_en && (wr_addr == 3'(int'(A_AL1_LO) + 2*k));

        tod_alarm_unit #(.TW(TW), .RW(RW)) u_alarm (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .now_ns     (now_ns),
            .wr_hi      (wr_hi),
            .wr_lo      (wr_lo),
            .wr_data    (wr_data),
            .active_high(alarm_pol[k]),
            .hit        (hit[k]),
            .fire       (fire[k]),
            .pin        (alarm_pin[k])
        );
    end

    for (genvar i = 0; i < N_TRAIN; i++) begin : g_train
        logic le;
        if (i < N_LOOP) begin : g_le
            assign le = loop_en[i];
        end else begin : g_nole
            assign le = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                period[i] <= '0;
            else if (wr_en && (wr_addr == 3'(int'(A_PER1) + i)))
                period[i] <= wr_data;
        end

        tod_pulse_train #(.RW(RW), .INCW(INCW)) u_train (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .inc       (tick_inc),
            .period    (period[i]),
            .run       (run_en),
            .align     (hit[0]),
            .hold_phase(no_realign),
            .loop_en   (le),
            .pulse     (pulse_pin[i]),
            .loop_q    (loop_out[i])
        );
    end

    always_comb begin
        evt = '0;
        for (int k = 0; k < N_ALARM; k++)
            evt[alarm_evt_bit(k)] = fire[k];
        for (int i = 0; i < N_TRAIN; i++)
            evt[train_evt_bit(i)] = pulse_pin[i];
    end

endmodule

// File: rtl/tod_alarm_pulse_chk.sv
module tod_alarm_pulse_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        run_en,
    input logic [31:0] evt,
    input logic [2:0]  pulse_pin,
    input logic [2:0]  loop_out
);
    AST_ALARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (evt[16] || evt[17]) |-> $past(tick)); // R5

    AST_TRAIN_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (|evt[7:5]) |-> $past(tick)); // R7

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!run_en) |-> (evt[7:5] == 3'b000)); // R6

    AST_LOOP_WITH_PIN: assert property (@(posedge clk) disable iff (rst)
        (|loop_out[1:0]) |-> ((loop_out[1:0] & ~pulse_pin[1:0]) == 2'b00)); // R10

    AST_LOOP3_QUIET: assert property (@(posedge clk) disable iff (rst)
        pulse_pin[2] |-> !loop_out[2]); // R10

endmodule

bind tod_alarm_pulse tod_alarm_pulse_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run_en   (run_en),
    .evt      (evt),
    .pulse_pin(pulse_pin),
    .loop_out (loop_out)
);

// File: tb/tod_alarm_pulse_tb.sv
module tod_alarm_pulse_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  tick_inc = 8'd4;
    logic [63:0] now_ns = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  alarm_pol = 2'b10;
    logic        run_en = 1'b0;
    logic        no_realign = 1'b0;
    logic [1:0]  loop_en = 2'b01;
    logic [31:0] evt;
    logic [1:0]  alarm_pin;
    logic [2:0]  pulse_pin;
    logic [2:0]  loop_out;

    int n_tests = 0;
    int n_fail  = 0;

    int m_phase [3];
    int m_per   [3];
    bit m_act   [3];

    always #2 clk = ~clk;

    tod_alarm_pulse u_dut (
        .clk(clk), .rst(rst), .tick(tick), .tick_inc(tick_inc), .now_ns(now_ns),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .alarm_pol(alarm_pol),
        .run_en(run_en), .no_realign(no_realign), .loop_en(loop_en),
        .evt(evt), .alarm_pin(alarm_pin), .pulse_pin(pulse_pin), .loop_out(loop_out)
    );

    // cmp, now, expected alarm 1 fire
    localparam logic [128:0] VEC [5] = '{
        {64'd1000,                 64'd999,                  1'b0},
        {64'd1000,                 64'd1000,                 1'b1},
        {64'h0000_0000_FFFF_FFFF,  64'h0000_0001_0000_0000,  1'b1},
        {64'h0000_0002_0000_0000,  64'h0000_0001_FFFF_FFFF,  1'b0},
        {64'd5,                    64'hFFFF_FFFF_FFFF_FFFF,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic arm1(input logic [63:0] v);
        wr(3'd1, v[31:0]);
        wr(3'd0, v[63:32]);
    endtask

    task automatic do_tick(input logic [63:0] t);
        tick = 1'b1; now_ns = t;
        cyc();
        tick = 1'b0;
    endtask

    // model tick for the trains; align = alarm 1 fires on this tick
    task automatic mtick(input logic [63:0] t, input bit align, input string req);
        logic [2:0] ep;
        ep = '0;
        for (int i = 0; i < 3; i++) begin
            if (!run_en) begin
                m_act[i] = 0; m_phase[i] = 0;
            end else if (align && (!m_act[i] || !no_realign)) begin
                m_act[i] = 1; m_phase[i] = 0;
            end else if (m_act[i] && m_per[i] != 0) begin
                m_phase[i] += tick_inc;
                if (m_phase[i] >= m_per[i]) begin
                    ep[i] = 1'b1;
                    m_phase[i] -= m_per[i];
                end
            end
        end
        do_tick(t);
        chk(pulse_pin == ep, req, pulse_pin, ep);
        chk(evt[7:5] == {ep[0], ep[1], ep[2]}, "R7 event bits", evt[7:5], {ep[0], ep[1], ep[2]});
        chk(loop_out == {1'b0, ep[1] & loop_en[1], ep[0] & loop_en[0]}, "R10 loopback",
            loop_out, {1'b0, ep[1] & loop_en[1], ep[0] & loop_en[0]});
        chk(!pulse_pin[2], "R8 zero period", pulse_pin[2], 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_phase[i] = 0; m_act[i] = 0; m_per[i] = 0; end
        repeat (3) cyc();
        chk(evt == 0 && pulse_pin == 0 && loop_out == 0, "R1 reset outputs", {evt, pulse_pin, loop_out}, 0);
        chk(alarm_pin == 2'b01, "R1 idle pins", alarm_pin, 2'b01);
        rst = 1'b0;
        cyc();
        chk(evt == 0 && alarm_pin == 2'b01, "R1 after reset", {evt, alarm_pin}, 2'b01);
        do_tick(64'hFFFF_FFFF_FFFF_FFFF);
        chk(evt == 0, "R1 nothing armed", evt, 0);

        // table of compare vectors, alarm 1 active low
        for (int v = 0; v < 5; v++) begin
            arm1(VEC[v][128:65]);
            do_tick(VEC[v][64:1]);
            chk(evt[16] == VEC[v][0], "R2 compare", evt[16], VEC[v][0]);
            chk(alarm_pin[0] == !VEC[v][0], "R4 active-low pin", alarm_pin[0], !VEC[v][0]);
        end

        // R3 one-shot and re-arm
        do_tick(64'hFFFF_FFFF_FFFF_FFFF);
        chk(evt[16] == 1'b0, "R3 no refire", evt[16], 0);
        wr(3'd1, 32'd0);
        do_tick(64'd10);
        chk(evt[16] == 1'b0, "R3 low write no arm", evt[16], 0);
        wr(3'd0, 32'd0);
        do_tick(64'd10);
        chk(evt[16] == 1'b1, "R3 high write arms", evt[16], 1);

        // R5 no tick, no fire
        arm1(64'd50);
        now_ns = 64'd100;
        repeat (3) begin
            cyc();
            chk(evt[16] == 1'b0, "R5 no tick", evt[16], 0);
        end
        do_tick(64'd100);
        chk(evt[16] == 1'b1, "R5 fires on tick", evt[16], 1);

        // R4 both alarms on one tick, opposite polarities
        arm1(64'd300);
        wr(3'd3, 32'd300);
        wr(3'd2, 32'd0);
        do_tick(64'd300);
        chk(evt[17:16] == 2'b11, "R2 both alarms", evt[17:16], 2'b11);
        chk(alarm_pin == 2'b10, "R4 pins on fire", alarm_pin, 2'b10);
        cyc();
        chk(alarm_pin == 2'b01 && evt[17:16] == 2'b00, "R4 pins back idle", alarm_pin, 2'b01);

        // trains
        wr(3'd4, 32'd12); m_per[0] = 12;
        wr(3'd5, 32'd8);  m_per[1] = 8;
        wr(3'd6, 32'd0);  m_per[2] = 0;
        run_en = 1'b1;
        for (int n = 0; n < 3; n++) mtick(64'd400, 1'b0, "R6 idle before alarm");
        arm1(64'd1000);
        mtick(64'd1000, 1'b1, "R6 start");
        chk(evt[16] == 1'b1, "R6 start alarm", evt[16], 1);
        for (int n = 0; n < 14; n++) mtick(64'd1100, 1'b0, "R7 train pulses");

        // R9 realign on the tick train 1 would pulse (phase 8 + 4 = 12)
        arm1(64'd2000);
        mtick(64'd2000, 1'b1, "R9 realign");
        chk(pulse_pin[0] == 1'b0, "R9 no pulse on realign", pulse_pin[0], 0);
        for (int n = 0; n < 5; n++) mtick(64'd2100, 1'b0, "R9 after realign");

        // R9 realign disabled: phase 8 again, match must not suppress pulse
        no_realign = 1'b1;
        arm1(64'd3000);
        mtick(64'd3000, 1'b1, "R9 hold phase");
        chk(pulse_pin[0] == 1'b1, "R9 pulse kept", pulse_pin[0], 1);
        loop_en = 2'b10;
        for (int n = 0; n < 6; n++) mtick(64'd3100, 1'b0, "R10 loop train 2");

        // R6 stop and no restart without alarm
        run_en = 1'b0;
        cyc();
        for (int n = 0; n < 4; n++) mtick(64'd4000, 1'b0, "R6 stopped");
        run_en = 1'b1;
        for (int n = 0; n < 4; n++) mtick(64'd4100, 1'b0, "R6 needs alarm");
        chk(evt == 0, "R6 idle evt", evt, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule